// File: doc/BRIEF.md
# Segment-Gated 16-bit Posit Multiplier

This block multiplies two 16-bit posit numbers that carry one exponent bit and returns the rounded posit product one clock later. Each operand is split into its sign, regime run, exponent bit and a left-aligned fraction. A negative operand is first negated in two's complement. The significand product is not formed by one wide array. It is formed by a 3x3 grid of 4x4 sub-multipliers, one for each pair of 4-bit fraction segments. The hidden-one cross terms are added beside the grid. All partial terms are reduced by 3:2 carry-save compressors and one final carry-propagate adder.

A grid cell is switched on only when both of its fraction segments hold at least one real fraction bit of their operand. How many real bits an operand has depends on how long its regime run is. An idle cell receives forced-zero operands, so it does not toggle. The enable pattern is brought out on a port so that a test can observe it. The product is normalised, rounded to nearest-even on the encoded bit string, and clamped to the largest and smallest positive magnitudes. The two special values, zero and NaR, bypass the arithmetic and keep every cell idle.

Top module: `posit_rgmul`

## Requirements
- R1: `p_o` and `seg_en_o` are registered and show the result for the operands sampled at the previous rising clock edge. While `rst` is high at a clock edge, both outputs become 0.
- R2: If neither operand is NaR (0x8000) and at least one operand is 0x0000, the result is 0x0000 and `seg_en_o` is 0.
- R3: If either operand is 0x8000, the result is 0x8000 and `seg_en_o` is 0. This holds even when the other operand is zero.
- R4: Operands are decoded as follows, reading from bit 15 downward. Bit 15 is the sign. A negative word is two's-complemented first. The regime is a run of identical bits starting at bit 14: k ones give regime k-1, and k zeros give regime -k. The run ends with one opposite terminator bit, unless the run reaches bit 0. Next comes one exponent bit, treated as 0 when no bits are left. All remaining bits are fraction bits below a hidden 1. The value is fraction times 2^(2*regime+exponent). Any exactly representable product is returned exactly, so multiplying by 0x4000 (+1.0) returns the other operand.
- R5: An inexact product is encoded as a bit string from the result scale: the regime run, the terminator, the exponent bit, then the fraction. This string is cut to 15 bits and rounded to nearest, with ties going to an even last bit.
- R6: A product scale of 28 or more gives magnitude 0x7FFF. A scale below -28 gives magnitude 0x0001. A product of two finite non-zero operands is never 0x0000 and never 0x8000.
- R7: For finite non-zero operands, the sign of the result is the XOR of the operand signs. Negating one operand gives the two's complement of the result.
- R8: Each operand has a fraction length fl, between 0 and 12. The fraction is split into three segments: segment 2 is its top 4 bits, segment 1 the next 4 bits, and segment 0 the lowest 4 bits. Segment s is active when fl >= 9-4*s. Bit `3*i+j` of `seg_en_o` is 1 exactly when segment i of operand A and segment j of operand B are both active, and neither operand is zero or NaR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| a_i | input | 16 | Posit operand A |
| b_i | input | 16 | Posit operand B |
| p_o | output | 16 | Registered posit product |
| seg_en_o | output | 9 | Registered sub-multiplier enables, bit 3*i+j for A segment i and B segment j |

## Verification
The block has one register stage, so both the product and the enable vector for a pair of operands are due exactly one rising edge after that pair is applied. The bench applies each pair on a falling edge. It pushes the expected product and enable pattern into a queue at that moment. On the next falling edge, half a period after the capturing edge, it pops the queue and compares both outputs. The checker properties likewise use a one-cycle implication from the sampled operands to the registered outputs.

// File: rtl/posit_rgmul_pkg.sv
package posit_rgmul_pkg;

  parameter int NB    = 16;
  parameter int ES    = 1;
  parameter int SEG_W = 4;

  localparam int FW    = NB - 3 - ES;
  localparam int NSEG  = FW / SEG_W;
  localparam int NCELL = NSEG * NSEG;
  localparam int SIGW  = FW + 1;
  localparam int PW    = 2 * SIGW;
  localparam int RUNW  = $clog2(NB) + 1;
  localparam int SCW   = $clog2(NB) + ES + 3;
  localparam int MAXSC = (NB - 2) << ES;

  typedef struct packed {
    logic                   sign;
    logic                   is_zero;
    logic                   is_nar;
    logic signed [SCW-1:0]  scale;
    logic [FW-1:0]          frac;
    logic [RUNW-1:0]        flen;
  } op_fields_t;

endpackage

// File: rtl/posit_rgmul_dec.sv
module posit_rgmul_dec
  import posit_rgmul_pkg::*;
(
  input  logic [NB-1:0] word_i,
  output op_fields_t    fld_o
);

  logic [NB-1:0]         mag;
  logic [NB-2:0]         body;
  logic                  lead;
  logic                  stop;
  logic [RUNW-1:0]       run;
  logic [RUNW-1:0]       rlen;
  logic [RUNW-1:0]       rest;
  logic [NB-2:0]         shifted;
  logic [ES-1:0]         expv;
  logic signed [SCW-1:0] regv;

  always_comb begin
    mag  = word_i[NB-1] ? (~word_i + 1'b1) : word_i;
    body = mag[NB-2:0];
    lead = body[NB-2];
    run  = '0;
    stop = 1'b0;
    for (int i = NB - 2; i >= 0; i--) begin
      if (!stop && (body[i] == lead)) run = run + 1'b1;
      else                            stop = 1'b1;
    end
    rlen    = (run >= RUNW'(NB - 2)) ? RUNW'(NB - 1) : run + 1'b1;
    rest    = RUNW'(NB - 1) - rlen;
    shifted = body << rlen;
    expv    = shifted[NB-2 -: ES];
    regv    = lead ? $signed(SCW'(run) - SCW'(1)) : $signed(-SCW'(run));

    fld_o.sign    = word_i[NB-1];
    fld_o.is_zero = (word_i == '0);
    fld_o.is_nar  = (word_i == {1'b1, {(NB-1){1'b0}}});
    fld_o.scale   = $signed((regv <<< ES) + $signed(SCW'(expv)));
    fld_o.frac    = shifted[NB-2-ES -: FW];
    fld_o.flen    = (rest > RUNW'(ES)) ? rest - RUNW'(ES) : '0;
  end

endmodule

// File: rtl/posit_rgmul_segmul.sv
module posit_rgmul_segmul
  import posit_rgmul_pkg::*;
(
  input  logic [FW-1:0]    fa_i,
  input  logic [FW-1:0]    fb_i,
  input  logic [NCELL-1:0] en_i,
  output logic [PW-1:0]    prod_o
);

  localparam int NT = NCELL + 3;

  logic [PW-1:0] terms [NT];

  for (genvar i = 0; i < NSEG; i++) begin : g_row
    for (genvar j = 0; j < NSEG; j++) begin : g_col
      logic [SEG_W-1:0]   opa;
      logic [SEG_W-1:0]   opb;
      logic [2*SEG_W-1:0] pp;
      assign opa = en_i[i*NSEG+j] ? fa_i[i*SEG_W +: SEG_W] : '0;
      assign opb = en_i[i*NSEG+j] ? fb_i[j*SEG_W +: SEG_W] : '0;
      assign pp  = opa * opb;
      assign terms[i*NSEG+j] = PW'(pp) << (SEG_W * (i + j));
    end
  end

  assign terms[NT-3] = PW'(fa_i) << FW;
  assign terms[NT-2] = PW'(fb_i) << FW;
  assign terms[NT-1] = PW'(1) << (2 * FW);

  logic [PW-1:0] acc_s;
  logic [PW-1:0] acc_c;
  logic [PW-1:0] nxt_s;
  logic [PW-1:0] nxt_c;

  always_comb begin
    acc_s = '0;
    acc_c = '0;
    for (int t = 0; t < NT; t++) begin
      nxt_s = acc_s ^ acc_c ^ terms[t];
      nxt_c = ((acc_s & acc_c) | (acc_s & terms[t]) | (acc_c & terms[t])) << 1;
      acc_s = nxt_s;
      acc_c = nxt_c;
    end
    prod_o = acc_s + acc_c;
  end

endmodule

// File: rtl/posit_rgmul_enc.sv
module posit_rgmul_enc
  import posit_rgmul_pkg::*;
(
  input  logic                  sign_i,
  input  logic                  zero_i,
  input  logic                  nar_i,
  input  logic signed [SCW-1:0] scale_i,
  input  logic [PW-1:0]         prod_i,
  output logic [NB-1:0]         word_o
);

  localparam int FNW = PW - 1;
  localparam int TW  = 1 + ES + FNW;
  localparam int XW  = TW + NB;

  logic signed [SCW-1:0] sc;
  logic signed [SCW-1:0] kr;
  logic [FNW-1:0]        fnorm;
  logic [SCW-1:0]        run;
  logic                  fill;
  logic                  term;
  logic [XW-1:0]         xv;
  logic [XW-1:0]         yv;
  logic [NB-2:0]         mant;
  logic [NB-2:0]         mant_r;
  logic                  guard;
  logic                  sticky;

  always_comb begin
    sc     = scale_i + (prod_i[PW-1] ? SCW'(1) : SCW'(0));
    fnorm  = prod_i[PW-1] ? prod_i[PW-2:0] : {prod_i[PW-3:0], 1'b0};
    kr     = sc >>> ES;
    fill   = (kr >= 0);
    term   = ~fill;
    run    = fill ? SCW'(kr + SCW'(1)) : SCW'(-kr);
    xv     = {term, sc[ES-1:0], fnorm, {NB{1'b0}}};
    yv     = fill ? ~((~xv) >> run) : (xv >> run);
    mant   = yv[XW-1 -: NB-1];
    guard  = yv[XW-NB];
    sticky = |yv[XW-NB-1:0];
    if (sc >= SCW'(MAXSC))       mant_r = '1;
    else if (sc < -SCW'(MAXSC))  mant_r = (NB-1)'(1);
    else                         mant_r = mant + (NB-1)'(guard & (sticky | mant[0]));

    if (nar_i)       word_o = {1'b1, {(NB-1){1'b0}}};
    else if (zero_i) word_o = '0;
    else if (sign_i) word_o = ~{1'b0, mant_r} + 1'b1;
    else             word_o = {1'b0, mant_r};
  end

endmodule

// File: rtl/posit_rgmul.sv
module posit_rgmul
  import posit_rgmul_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [NB-1:0]    a_i,
  input  logic [NB-1:0]    b_i,
  output logic [NB-1:0]    p_o,
  output logic [NCELL-1:0] seg_en_o
);

  op_fields_t            fa;
  op_fields_t            fb;
  logic [NSEG-1:0]       act_a;
  logic [NSEG-1:0]       act_b;
  logic [NCELL-1:0]      cell_en;
  logic                  special;
  logic [PW-1:0]         prod;
  logic signed [SCW-1:0] scale_sum;
  logic [NB-1:0]         word;

  posit_rgmul_dec u_dec_a (.word_i(a_i), .fld_o(fa));
  posit_rgmul_dec u_dec_b (.word_i(b_i), .fld_o(fb));

  assign special = fa.is_zero | fb.is_zero | fa.is_nar | fb.is_nar;

  for (genvar s = 0; s < NSEG; s++) begin : g_act
    localparam int NEED = FW - SEG_W * s - SEG_W + 1;
    assign act_a[s] = (fa.flen >= RUNW'(NEED));
    assign act_b[s] = (fb.flen >= RUNW'(NEED));
  end

  for (genvar i = 0; i < NSEG; i++) begin : g_en_r
    for (genvar j = 0; j < NSEG; j++) begin : g_en_c
      assign cell_en[i*NSEG+j] = act_a[i] & act_b[j] & ~special;
    end
  end

  posit_rgmul_segmul u_mul (
    .fa_i  (fa.frac),
    .fb_i  (fb.frac),
    .en_i  (cell_en),
    .prod_o(prod)
  );

  assign scale_sum = fa.scale + fb.scale;

  posit_rgmul_enc u_enc (
    .sign_i (fa.sign ^ fb.sign),
    .zero_i (fa.is_zero | fb.is_zero),
    .nar_i  (fa.is_nar | fb.is_nar),
    .scale_i(scale_sum),
    .prod_i (prod),
    .word_o (word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      p_o      <= '0;
      seg_en_o <= '0;
    end else begin
      p_o      <= word;
      seg_en_o <= cell_en;
    end
  end

endmodule

// File: rtl/posit_rgmul_chk.sv
module posit_rgmul_chk
  import posit_rgmul_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic [NB-1:0]    a_i,
  input logic [NB-1:0]    b_i,
  input logic [NB-1:0]    p_o,
  input logic [NCELL-1:0] seg_en_o
);

  localparam logic [NB-1:0] NAR = {1'b1, {(NB-1){1'b0}}};

  logic finite_nz;
  assign finite_nz = (a_i != '0) && (b_i != '0) && (a_i != NAR) && (b_i != NAR);

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (p_o == '0 && seg_en_o == '0)); // R1

  AST_ZERO_OUT: assert property (@(posedge clk) disable iff (rst)
    ((a_i == '0 || b_i == '0) && a_i != NAR && b_i != NAR) |=> (p_o == '0 && seg_en_o == '0)); // R2

  AST_NAR_OUT: assert property (@(posedge clk) disable iff (rst)
    (a_i == NAR || b_i == NAR) |=> (p_o == NAR && seg_en_o == '0)); // R3

  AST_NO_ZERO_OR_NAR: assert property (@(posedge clk) disable iff (rst)
    finite_nz |=> (p_o != '0 && p_o != NAR)); // R6

  AST_SIGN_XOR: assert property (@(posedge clk) disable iff (rst)
    finite_nz |=> (p_o[NB-1] == ($past(a_i[NB-1]) ^ $past(b_i[NB-1])))); // R7

  AST_ONE_IDENTITY: assert property (@(posedge clk) disable iff (rst)
    (b_i == {2'b01, {(NB-2){1'b0}}}) |=> (p_o == $past(a_i))); // R4

endmodule

bind posit_rgmul posit_rgmul_chk chk_i (.*);

// File: tb/posit_rgmul_tb_top.sv
module posit_rgmul_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] a_i = '0;
  logic [15:0] b_i = '0;
  logic [15:0] p_o;
  logic [8:0]  seg_en_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [15:0] exp_p[$];
  logic [8:0]  exp_e[$];
  string       exp_tag[$];
  logic [15:0] exp_a[$];
  logic [15:0] exp_b[$];

  posit_rgmul dut_i (.clk(clk), .rst(rst), .a_i(a_i), .b_i(b_i), .p_o(p_o), .seg_en_o(seg_en_o));

  always #10 clk = ~clk;

  // Field walk of one operand, bit by bit from the top (R4)
  function automatic void unpack(input logic [15:0] x, output int sc, output longint sig, output int fl);
    logic [15:0] m = x[15] ? -x : x;
    int i = 14;
    bit ld = m[14];
    int k = 0;
    int r;
    int e = 0;
    longint f = 0;
    while (i >= 0 && m[i] == ld) begin k++; i--; end
    if (i >= 0) i--;
    r = ld ? k - 1 : -k;
    if (i >= 0) begin e = m[i]; i--; end
    fl = 0;
    while (i >= 0) begin f = f * 2 + m[i]; fl++; i--; end
    sig = ((longint'(1) << fl) | f) << (12 - fl);
    sc = 2 * r + e;
  endfunction

  function automatic logic [15:0] ref_mul(input logic [15:0] a, input logic [15:0] b);
    int sca, scb, fla, flb, s, kr, nf;
    longint siga, sigb, p;
    bit q[$];
    logic [14:0] mag;
    bit g, st;
    if (a == 16'h8000 || b == 16'h8000) return 16'h8000;
    if (a == 0 || b == 0) return 16'h0000;
    unpack(a, sca, siga, fla);
    unpack(b, scb, sigb, flb);
    p = siga * sigb;
    s = sca + scb;
    if (p >= (longint'(1) << 25)) begin s++; nf = 25; end else nf = 24;
    if (s >= 28) mag = 15'h7fff;
    else if (s < -28) mag = 15'h0001;
    else begin
      kr = s >>> 1;
      if (kr >= 0) begin
        for (int i = 0; i <= kr; i++) q.push_back(1'b1);
        q.push_back(1'b0);
      end else begin
        for (int i = 0; i < -kr; i++) q.push_back(1'b0);
        q.push_back(1'b1);
      end
      q.push_back(s[0]);
      for (int i = nf - 1; i >= 0; i--) q.push_back(p[i]);
      mag = '0;
      for (int i = 0; i < 15; i++) mag = {mag[13:0], (q.size() > 0) ? q.pop_front() : 1'b0};
      g = (q.size() > 0) ? q.pop_front() : 1'b0;
      st = 1'b0;
      while (q.size() > 0) st |= q.pop_front();
      if (g && (st || mag[0])) mag = mag + 1'b1;
    end
    return (a[15] ^ b[15]) ? -{1'b0, mag} : {1'b0, mag};
  endfunction

  // Cell enable rule (R8)
  function automatic logic [8:0] ref_en(input logic [15:0] a, input logic [15:0] b);
    int sca, scb, fla, flb;
    longint siga, sigb;
    logic [8:0] en = '0;
    if (a == 0 || b == 0 || a == 16'h8000 || b == 16'h8000) return '0;
    unpack(a, sca, siga, fla);
    unpack(b, scb, sigb, flb);
    for (int i = 0; i < 3; i++)
      for (int j = 0; j < 3; j++)
        en[3*i+j] = (fla >= 9 - 4 * i) && (flb >= 9 - 4 * j);
    return en;
  endfunction

  task automatic compare_pending();
    logic [15:0] ep, ea, eb;
    logic [8:0]  ee;
    string       tg;
    if (exp_p.size() == 0) return;
    ep = exp_p.pop_front(); ee = exp_e.pop_front(); tg = exp_tag.pop_front();
    ea = exp_a.pop_front(); eb = exp_b.pop_front();
    checks++;
    if (p_o !== ep) begin
      errors++;
      $display("FAIL %s a=%h b=%h p_o got %h expected %h", tg, ea, eb, p_o, ep);
    end
    checks++;
    if (seg_en_o !== ee) begin
      errors++;
      $display("FAIL R8 a=%h b=%h seg_en_o got %b expected %b", ea, eb, seg_en_o, ee);
    end
  endtask

  // Apply on a falling edge; the result is due at the next falling edge (R1)
  task automatic step(input logic [15:0] a, input logic [15:0] b, input string tg);
    @(negedge clk);
    compare_pending();
    a_i = a;
    b_i = b;
    exp_p.push_back(ref_mul(a, b));
    exp_e.push_back(ref_en(a, b));
    exp_tag.push_back(tg);
    exp_a.push_back(a);
    exp_b.push_back(b);
  endtask

  initial begin
    logic [15:0] ra, rb;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (p_o !== 16'h0 || seg_en_o !== 9'h0) begin
      errors++;
      $display("FAIL R1 reset state got %h/%b expected 0000/000000000", p_o, seg_en_o);
    end
    rst = 1'b0;

    step(16'h4000, 16'h4000, "R4 one*one");
    step(16'h5000, 16'h5000, "R4 two*two");
    step(16'h4800, 16'h4800, "R4 1.5*1.5");
    step(16'hC000, 16'hC000, "R7 neg*neg");
    step(16'hC000, 16'h4800, "R7 neg*pos");
    step(16'h0000, 16'h1234, "R2 zero*x");
    step(16'h5555, 16'h0000, "R2 x*zero");
    step(16'h8000, 16'h4000, "R3 nar*one");
    step(16'h0000, 16'h8000, "R3 zero*nar");
    step(16'h8000, 16'h8000, "R3 nar*nar");
    step(16'h7FFF, 16'h7FFF, "R6 maxpos*maxpos");
    step(16'h0001, 16'h0001, "R6 minpos*minpos");
    step(16'h7FFF, 16'h0001, "R6 maxpos*minpos");
    step(16'h8001, 16'h7FFF, "R6 neg maxpos");
    step(16'h7FF0, 16'h7F00, "R6 near max");
    step(16'h0003, 16'h0010, "R6 near min");
    step(16'h4001, 16'h4001, "R5 tiny fraction");
    step(16'h47FF, 16'h47FF, "R5 full fraction");
    step(16'h7000, 16'h4FFF, "R8 short fraction");

    // Identity sweep over every code (R4)
    for (int v = 0; v < 65536; v++) step(16'(v), 16'h4000, "R4 identity");

    // Random pairs and their negated twins (R5, R7)
    for (int n = 0; n < 20000; n++) begin
      ra = 16'($urandom);
      rb = 16'($urandom);
      step(ra, rb, "R5 random");
      step(-ra, rb, "R7 negated");
    end

    @(negedge clk);
    compare_pending();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired, run did not complete");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule